// File: doc/BRIEF.md
# Burst-Limited Round-Robin Bus Arbiter

This block chooses which of several DMA channels drives a shared bus master port. Each channel raises a request while it has data left to move, and reports whether its staging FIFO is full. The block grants the port to one channel at a time. The winner is picked by rotating priority, and the winner keeps the port for a whole burst of acknowledged words.

A grant ends in one of three ways: the burst reaches its configured length, the winner's FIFO fills, or the winner withdraws its request. After the grant ends, the port always stays idle for one clock before the next grant starts. Cycle-valid and strobe show when the port is owned. A word counter shows how many words have been acknowledged within the current grant.

The burst length comes from a configuration input and is captured when a grant starts. The largest allowed burst is a power-of-two parameter.

Top module: `dma_burst_arb`

## Requirements
- R1: At most one bit of `grant_o` is high at any time. `cyc_o` and `stb_o` are high exactly when a grant is held.
- R2: The holder keeps the grant while its request is high, its FIFO is not full and fewer words than the burst length have been acknowledged. It is released in the cycle after the acknowledge that completes the burst.
- R3: Between any two grants, including two grants to the same channel, there is exactly one cycle with no grant. If any channel is eligible in that idle cycle, the next grant appears in the following cycle.
- R4: Each arbitration searches the channels in increasing index order, wrapping around. The search starts at the index just past the most recently granted channel.
- R5: `word_cnt_o` is the number of cycles in the current grant in which `bus_ack_i` was high. It is 0 in the first cycle of every grant and whenever no grant is held. `bus_ack_i` has no effect while no grant is held.
- R6: If the holder's `fifo_full_i` bit is high in a granted cycle, the grant is released in the next cycle.
- R7: If the holder's `req_i` bit is low in a granted cycle, the grant is released in the next cycle.
- R8: A channel is eligible only when its `req_i` bit is high and its `fifo_full_i` bit is low. With no eligible channel, no grant is given.
- R9: `burst_len_i` is captured when a grant starts, and later changes do not affect that grant. A value of 0, or a value greater than `BURST_MAX`, means `BURST_MAX` words.
- R10: After reset, no grant is held, `cyc_o`, `stb_o` and `word_cnt_o` are 0, and the search pointer is at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_CH | Per-channel request: the channel has data left to move |
| fifo_full_i | input | N_CH | Per-channel FIFO full flag |
| burst_len_i | input | $clog2(BURST_MAX)+1 | Burst length in words, captured at grant start |
| bus_ack_i | input | 1 | Bus acknowledge for the current word |
| grant_o | output | N_CH | One-hot grant |
| cyc_o | output | 1 | Bus cycle valid |
| stb_o | output | 1 | Bus strobe |
| word_cnt_o | output | $clog2(BURST_MAX)+1 | Words acknowledged in the current grant |

## Verification
A wrong round-robin pointer shows up at the very next arbitration, as a grant on the wrong channel one cycle after the idle gap. A wrong word counter or a wrong captured length shows up as a grant that ends one or more cycles early or late. Any missed release shows up as `cyc_o` still high in the cycle after a full flag, a withdrawn request or the final acknowledge. Every scenario therefore compares the grant, the strobes and the counter cycle by cycle from the first grant to the next idle cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_OWN  = 1'b1
    } arb_state_e;

    // index of the channel after v, wrapping at n
    function automatic int unsigned wrap_next(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

    // effective burst length: 0 or out of range means the maximum
    function automatic int unsigned eff_len(int unsigned len, int unsigned max_len);
        return (len == 0 || len > max_len) ? max_len : len;
    endfunction

endpackage

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
    parameter int N_CH = 4,
    localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] elig_i,
    input  logic [IW-1:0]   ptr_i,
    output logic            found_o,
    output logic [IW-1:0]   win_o
);

    // candidate index for each search offset
    logic [IW-1:0] cand [N_CH];

    for (genvar k = 0; k < N_CH; k++) begin : g_cand
        always_comb begin
            int t;
            t = int'(ptr_i) + k;
            if (t >= N_CH) t = t - N_CH;
            cand[k] = IW'(t);
        end
    end

    // lowest offset wins, so scan from the highest down
    always_comb begin
        found_o = 1'b0;
        win_o   = '0;
        for (int k = N_CH - 1; k >= 0; k--) begin
            if (elig_i[cand[k]]) begin
                found_o = 1'b1;
                win_o   = cand[k];
            end
        end
    end

endmodule

// File: rtl/dma_burst_ctr.sv
module dma_burst_ctr #(
    parameter int BURST_MAX = 256,
    localparam int CW = $clog2(BURST_MAX) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          inc_i,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);
    import dma_arb_pkg::*;

    logic [CW-1:0] limit_q;
    logic [CW-1:0] len_eff;

    always_comb begin
        len_eff = CW'(eff_len(int'(len_i), BURST_MAX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= CW'(BURST_MAX);
        end else if (load_i) begin
            limit_q <= len_eff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + CW'(1);
        end
    end

    assign last_o = inc_i && ((cnt_o + CW'(1)) == limit_q);

endmodule

// File: rtl/dma_burst_arb.sv
module dma_burst_arb #(
    parameter int N_CH      = 4,
    parameter int BURST_MAX = 256,
    localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int CW = $clog2(BURST_MAX) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] req_i,
    input  logic [N_CH-1:0] fifo_full_i,
    input  logic [CW-1:0]   burst_len_i,
    input  logic            bus_ack_i,
    output logic [N_CH-1:0] grant_o,
    output logic            cyc_o,
    output logic            stb_o,
    output logic [CW-1:0]   word_cnt_o
);
    import dma_arb_pkg::*;

    arb_state_e    state_q;
    logic [IW-1:0] cur_q;
    logic [IW-1:0] ptr_q;

    logic [N_CH-1:0] elig;
    logic            found;
    logic [IW-1:0]   win;
    logic            own;
    logic            last_word;
    logic            end_own;

    assign elig = req_i & ~fifo_full_i;
    assign own  = (state_q == ARB_OWN);

    dma_rr_pick #(.N_CH(N_CH)) u_pick (
        .elig_i  (elig),
        .ptr_i   (ptr_q),
        .found_o (found),
        .win_o   (win)
    );

    assign end_own = own && (!req_i[cur_q] || fifo_full_i[cur_q] || last_word);

    dma_burst_ctr #(.BURST_MAX(BURST_MAX)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .clear_i (!own || end_own),
        .inc_i   (own && bus_ack_i),
        .load_i  (!own),
        .len_i   (burst_len_i),
        .cnt_o   (word_cnt_o),
        .last_o  (last_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            cur_q   <= '0;
            ptr_q   <= '0;
        end else begin
            case (state_q)
                ARB_IDLE: begin
                    if (found) begin
                        state_q <= ARB_OWN;
                        cur_q   <= win;
                        ptr_q   <= IW'(wrap_next(int'(win), N_CH));
                    end
                end
                ARB_OWN: begin
                    if (end_own) state_q <= ARB_IDLE;
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_grant
        assign grant_o[i] = own && (cur_q == IW'(i));
    end

    assign cyc_o = own;
    assign stb_o = own;

endmodule

// File: rtl/dma_burst_arb_chk.sv
module dma_burst_arb_chk #(
    parameter int N_CH      = 4,
    parameter int BURST_MAX = 256,
    localparam int CW = $clog2(BURST_MAX) + 1
) (
    input logic            clk,
    input logic            rst,
    input logic [N_CH-1:0] req_i,
    input logic [N_CH-1:0] fifo_full_i,
    input logic            bus_ack_i,
    input logic [N_CH-1:0] grant_o,
    input logic            cyc_o,
    input logic            stb_o,
    input logic [CW-1:0]   word_cnt_o
);

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o)); // R1

    AST_CYC_HAS_GRANT: assert property (@(posedge clk) disable iff (rst)
        cyc_o |-> $onehot(grant_o)); // R1

    AST_STB_WITH_CYC: assert property (@(posedge clk) disable iff (rst)
        stb_o == cyc_o); // R1

    AST_CNT_BELOW_MAX: assert property (@(posedge clk) disable iff (rst)
        word_cnt_o < CW'(BURST_MAX)); // R2

    AST_NO_DIRECT_HANDOFF: assert property (@(posedge clk) disable iff (rst)
        cyc_o |=> (!cyc_o || grant_o == $past(grant_o))); // R3

    AST_SINGLE_GAP: assert property (@(posedge clk) disable iff (rst)
        ($fell(cyc_o) && |(req_i & ~fifo_full_i)) |=> cyc_o); // R3

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cyc_o |-> word_cnt_o == '0); // R5

    AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cyc_o && !bus_ack_i) |=> (!cyc_o || $stable(word_cnt_o))); // R5

    AST_FULL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (cyc_o && |(grant_o & fifo_full_i)) |=> !cyc_o); // R6

    AST_DROP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (cyc_o && !(|(grant_o & req_i))) |=> !cyc_o); // R7

    AST_NO_ELIG_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (!cyc_o && !(|(req_i & ~fifo_full_i))) |=> !cyc_o); // R8

endmodule

bind dma_burst_arb dma_burst_arb_chk #(.N_CH(N_CH), .BURST_MAX(BURST_MAX)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .fifo_full_i (fifo_full_i),
    .bus_ack_i   (bus_ack_i),
    .grant_o     (grant_o),
    .cyc_o       (cyc_o),
    .stb_o       (stb_o),
    .word_cnt_o  (word_cnt_o)
);

// File: tb/tb_dma_burst_arb.sv
`timescale 1ns/1ps
module tb_dma_burst_arb;
    localparam int N  = 4;
    localparam int BM = 256;
    localparam int CW = $clog2(BM) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  full = '0;
    logic [CW-1:0] blen = '0;
    logic          ack = 1'b0;
    logic [N-1:0]  grant;
    logic          cyc, stb;
    logic [CW-1:0] cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    dma_burst_arb #(.N_CH(N), .BURST_MAX(BM)) dut (
        .clk(clk), .rst(rst), .req_i(req), .fifo_full_i(full),
        .burst_len_i(blen), .bus_ack_i(ack), .grant_o(grant),
        .cyc_o(cyc), .stb_o(stb), .word_cnt_o(cnt)
    );

    always #2.5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // compare grant, strobes and counter; a zero grant means the idle state
    task automatic chk(string tag, logic [N-1:0] eg, int ec);
        n_chk++;
        if (grant !== eg || cyc !== (eg != 0) || stb !== (eg != 0) || cnt !== CW'(ec)) begin
            n_fail++;
            $display("FAIL %s: grant=%b cyc=%b stb=%b cnt=%0d, expected grant=%b cyc=%b cnt=%0d",
                     tag, grant, cyc, stb, cnt, eg, (eg != 0), ec);
        end
    endtask

    function automatic logic [N-1:0] oh(int ch);
        return N'(1) << ch;
    endfunction

    task automatic go_idle();
        req = '0; full = '0; ack = 1'b0;
        repeat (3) tick();
    endtask

    task automatic t_reset();
        chk("R10 reset", '0, 0);
    endtask

    task automatic t_rr_all();
        int seq [5] = '{0, 1, 2, 3, 0};
        req = '1; blen = CW'(2); ack = 1'b1;
        foreach (seq[i]) begin
            tick(); chk("R4 rotation grant", oh(seq[i]), 0);
            tick(); chk("R2 burst word 2", oh(seq[i]), 1);
            tick(); chk("R3 gap", '0, 0);
        end
        go_idle();
    endtask

    task automatic t_rr_sparse();
        int seq [3] = '{2, 0, 2};
        req = 4'b0101; blen = CW'(1); ack = 1'b1;
        foreach (seq[i]) begin
            tick(); chk("R4 sparse rotation", oh(seq[i]), 0);
            tick(); chk("R3 gap after single word", '0, 0);
        end
        go_idle();
    endtask

    task automatic t_single();
        req = 4'b0010; blen = CW'(4); ack = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick(); chk("R2 hold for burst", oh(1), k);
        end
        tick(); chk("R3 release after burst", '0, 0);
        tick(); chk("R3 regrant same channel", oh(1), 0);
        req = '0; ack = 1'b0;
        tick(); chk("R7 release on drop", '0, 0);
        go_idle();
    endtask

    task automatic t_ack_gaps();
        req = 4'b1000; blen = CW'(3); ack = 1'b0;
        tick(); chk("R5 first cycle zero", oh(3), 0);
        tick(); chk("R5 no ack no count", oh(3), 0);
        ack = 1'b1;
        tick(); chk("R5 count on ack", oh(3), 1);
        ack = 1'b0;
        tick(); chk("R5 hold without ack", oh(3), 1);
        tick(); chk("R5 hold without ack", oh(3), 1);
        ack = 1'b1;
        tick(); chk("R5 second ack", oh(3), 2);
        tick(); chk("R2 released after third ack", '0, 0);
        req = '0;
        tick(); chk("R5 ack ignored while idle", '0, 0);
        tick(); chk("R5 ack ignored while idle", '0, 0);
        go_idle();
    endtask

    task automatic t_full();
        req = 4'b0011; blen = CW'(8); ack = 1'b1;
        tick(); chk("R6 grant ch0", oh(0), 0);
        tick(); chk("R6 counting", oh(0), 1);
        full = 4'b0001;
        tick(); chk("R6 release on full", '0, 0);
        tick(); chk("R3 next channel after full", oh(1), 0);
        req = '0; full = '0;
        tick(); chk("R7 release", '0, 0);
        go_idle();
    endtask

    task automatic t_elig();
        req = 4'b1001; full = 4'b1000; blen = CW'(2); ack = 1'b0;
        tick(); chk("R8 full channel skipped", oh(0), 0);
        req = '0; full = '0;
        tick(); chk("R8 release", '0, 0);
        req = 4'b0001; full = 4'b0001;
        for (int k = 0; k < 3; k++) begin
            tick(); chk("R8 no eligible no grant", '0, 0);
        end
        go_idle();
    endtask

    task automatic t_drop();
        req = 4'b0010; blen = CW'(8); ack = 1'b1;
        tick(); chk("R7 grant", oh(1), 0);
        tick(); chk("R7 counting", oh(1), 1);
        req = '0;
        tick(); chk("R7 release on drop", '0, 0);
        go_idle();
    endtask

    task automatic t_len_latch();
        req = 4'b0100; blen = CW'(3); ack = 1'b1;
        tick(); chk("R9 grant", oh(2), 0);
        blen = CW'(1);
        tick(); chk("R9 length kept", oh(2), 1);
        tick(); chk("R9 length kept", oh(2), 2);
        tick(); chk("R9 release at captured length", '0, 0);
        go_idle();
    endtask

    task automatic t_len_max(int lenv, int ch);
        req = oh(ch); blen = CW'(lenv); ack = 1'b1;
        for (int k = 0; k < BM; k++) begin
            tick(); chk("R9 maximum burst", oh(ch), k);
        end
        tick(); chk("R9 release after maximum burst", '0, 0);
        go_idle();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        t_reset();
        t_rr_all();          // pointer ends at 1
        t_rr_sparse();       // pointer ends at 3
        t_single();          // pointer ends at 2
        t_ack_gaps();        // pointer ends at 0
        t_full();            // pointer ends at 2
        t_elig();            // pointer ends at 1
        t_drop();            // pointer ends at 2
        t_len_latch();       // pointer ends at 3
        t_len_max(0, 3);
        t_len_max(511, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule